// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one WIDTH-bit integer by another over several clock cycles, using a single left-shifting register. The register is 2*WIDTH+1 bits wide. Its upper WIDTH+1 bits hold the partial remainder. Its lower WIDTH bits start with the dividend, and quotient bits replace the dividend bits as it shifts. The divisor is captured once and stays fixed. In each iteration the upper part is compared with the divisor. If the upper part is large enough, the divisor is subtracted and a quotient bit of 1 enters at the bottom; otherwise a 0 enters. The register is shifted left once before the loop, which saves an iteration. As a result the finished remainder sits one place too far left and is shifted right by one when it is read out.

Signed operation divides the operand magnitudes and then applies signs. The quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. A client pulses `start` while `busy` is low. Results are valid when the one-cycle `done` pulse appears, and they are held until the next `done`.

The controller has four states:
- ST_IDLE: waiting. A start moves it to ST_PRESHIFT and captures the operands.
- ST_PRESHIFT: the single pre-loop left shift, then always ST_ITER.
- ST_ITER: one compare/subtract/shift per cycle, for WIDTH cycles, then ST_FINISH.
- ST_FINISH: the remainder correction, the sign fix and the output register load, then ST_IDLE.

Top module: `seq_restoring_div`

## Requirements
- R1: After reset, busy, done, div_by_zero, quotient and remainder are all 0.
- R2: A start sampled while busy is low begins an operation. busy is high from the next cycle until done is asserted. done is high for exactly one cycle, WIDTH+2 rising edges after the edge that sampled start, and busy is low in that same cycle.
- R3: start is ignored while busy is high. The running operation's result and timing do not change, and no extra done follows.
- R4: With is_signed=0, both operands are unsigned, quotient = floor(dividend/divisor) and remainder = dividend mod divisor.
- R5: With is_signed=1, both operands are two's complement. The quotient is the magnitude quotient, negated when the operand signs differ, so it is truncated toward zero. It wraps modulo 2^WIDTH, so the most negative value divided by -1 returns the most negative value.
- R6: With is_signed=1 and a non-zero divisor, a non-zero remainder has the sign of the dividend, and its magnitude is less than the divisor's magnitude (for example, -7 / -2 gives quotient 3 and remainder -1).
- R7: A zero divisor gives div_by_zero=1, quotient all ones and remainder equal to the raw dividend, in either mode, with the same latency as any other operation. div_by_zero returns to 0 at the next done whose divisor is non-zero.
- R8: quotient, remainder and div_by_zero hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | WIDTH | Dividend |
| divisor | input | WIDTH | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quotient | output | WIDTH | Quotient |
| remainder | output | WIDTH | Remainder |
| div_by_zero | output | 1 | Last operation had a zero divisor |

## Verification
The bench runs every operand pair of a 4-bit configuration in both modes, so every sign combination is covered. The sweep includes the most negative dividend divided by -1, which a design with a mis-sized magnitude path would return as garbage instead of the wrapped value. It also includes remainders that would overflow a WIDTH-bit upper half; a design without the extra top bit would there return a wrong quotient bit and a remainder not smaller than the divisor. A missing final right shift shows up as remainders that are doubled, and a remainder sign tied to the quotient sign shows up in the mixed-sign cases. The bench also checks the latency of every operation, a start pulsed mid-operation, and zero divisors followed by non-zero ones.

// File: rtl/divr_pkg.sv
package divr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRESHIFT,
        ST_ITER,
        ST_FINISH
    } divr_state_e;
endpackage

// File: rtl/divr_sign_prep.sv
module divr_sign_prep #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    input  logic             signed_mode_i,
    output logic [WIDTH-1:0] num_mag_o,
    output logic [WIDTH-1:0] den_mag_o,
    output logic             neg_quo_o,
    output logic             neg_rem_o,
    output logic             den_zero_o
);
    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg    = signed_mode_i & num_i[WIDTH-1];
        den_neg    = signed_mode_i & den_i[WIDTH-1];
        num_mag_o  = num_neg ? (~num_i + 1'b1) : num_i;
        den_mag_o  = den_neg ? (~den_i + 1'b1) : den_i;
        neg_quo_o  = num_neg ^ den_neg;
        neg_rem_o  = num_neg;
        den_zero_o = (den_i == '0);
    end
endmodule

// File: rtl/divr_step.sv
module divr_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   upper_i,
    input  logic [WIDTH-1:0] lower_i,
    input  logic [WIDTH-1:0] den_mag_i,
    output logic [WIDTH:0]   upper_o,
    output logic [WIDTH-1:0] lower_o
);
    logic           fits;
    logic [WIDTH:0] diff;

    always_comb begin
        fits    = (upper_i >= {1'b0, den_mag_i});
        diff    = fits ? (upper_i - {1'b0, den_mag_i}) : upper_i;
        upper_o = {diff[WIDTH-1:0], lower_i[WIDTH-1]};
        lower_o = {lower_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/divr_sign_fix.sv
module divr_sign_fix #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   upper_i,
    input  logic [WIDTH-1:0] lower_i,
    input  logic [WIDTH-1:0] num_raw_i,
    input  logic             neg_quo_i,
    input  logic             neg_rem_i,
    input  logic             den_zero_i,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);
    logic [WIDTH-1:0] rem_mag;

    always_comb begin
        rem_mag = upper_i[WIDTH:1];
        if (den_zero_i) begin
            quo_o = '1;
            rem_o = num_raw_i;
        end else begin
            quo_o = neg_quo_i ? (~lower_i + 1'b1) : lower_i;
            rem_o = neg_rem_i ? (~rem_mag + 1'b1) : rem_mag;
        end
    end
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div
    import divr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_by_zero
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

    divr_state_e state, state_nx;
    logic [CW-1:0]    iter_cnt;
    logic [WIDTH:0]   upper_q;
    logic [WIDTH-1:0] lower_q;
    logic [WIDTH-1:0] den_mag_q;
    logic [WIDTH-1:0] num_raw_q;
    logic             neg_quo_q, neg_rem_q, den_zero_q, signed_q;

    logic [WIDTH-1:0] num_mag_w, den_mag_w;
    logic             neg_quo_w, neg_rem_w, den_zero_w;
    logic [WIDTH:0]   upper_nx;
    logic [WIDTH-1:0] lower_nx;
    logic [WIDTH-1:0] quo_w, rem_w;

    divr_sign_prep #(.WIDTH(WIDTH)) prep_i (
        .num_i(dividend), .den_i(divisor), .signed_mode_i(is_signed),
        .num_mag_o(num_mag_w), .den_mag_o(den_mag_w),
        .neg_quo_o(neg_quo_w), .neg_rem_o(neg_rem_w), .den_zero_o(den_zero_w)
    );

    divr_step #(.WIDTH(WIDTH)) step_i (
        .upper_i(upper_q), .lower_i(lower_q), .den_mag_i(den_mag_q),
        .upper_o(upper_nx), .lower_o(lower_nx)
    );

    divr_sign_fix #(.WIDTH(WIDTH)) fix_i (
        .upper_i(upper_q), .lower_i(lower_q), .num_raw_i(num_raw_q),
        .neg_quo_i(neg_quo_q), .neg_rem_i(neg_rem_q), .den_zero_i(den_zero_q),
        .quo_o(quo_w), .rem_o(rem_w)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_PRESHIFT;
            ST_PRESHIFT: state_nx = ST_ITER;
            ST_ITER:     if (iter_cnt == LAST_ITER) state_nx = ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath: shifting register, counter, captured operand facts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_cnt   <= '0;
            upper_q    <= '0;
            lower_q    <= '0;
            den_mag_q  <= '0;
            num_raw_q  <= '0;
            neg_quo_q  <= 1'b0;
            neg_rem_q  <= 1'b0;
            den_zero_q <= 1'b0;
            signed_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    upper_q    <= '0;
                    lower_q    <= num_mag_w;
                    den_mag_q  <= den_mag_w;
                    num_raw_q  <= dividend;
                    neg_quo_q  <= neg_quo_w;
                    neg_rem_q  <= neg_rem_w;
                    den_zero_q <= den_zero_w;
                    signed_q   <= is_signed;
                    iter_cnt   <= '0;
                end
                ST_PRESHIFT: {upper_q, lower_q} <= {upper_q[WIDTH-1:0], lower_q, 1'b0};
                ST_ITER: begin
                    upper_q  <= upper_nx;
                    lower_q  <= lower_nx;
                    iter_cnt <= iter_cnt + 1'b1;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done        <= 1'b0;
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else begin
            done <= (state == ST_FINISH);
            if (state == ST_FINISH) begin
                quotient    <= quo_w;
                remainder   <= rem_w;
                div_by_zero <= den_zero_q;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    // R2
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2
    iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER) |-> (iter_cnt < CW'(WIDTH)));
    // R6
    rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && !den_zero_q) |-> (upper_q[WIDTH:1] < den_mag_q));
    // R6
    rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && signed_q && remainder != '0) |-> (remainder[WIDTH-1] == num_raw_q[WIDTH-1]));
    // R7
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == '1 && remainder == num_raw_q));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(state == ST_FINISH)) |-> $stable(quotient));
endmodule

// File: tb/seq_restoring_div_tb.sv
module seq_restoring_div_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    seq_restoring_div #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_of(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                             output logic [W-1:0] q, output logic [W-1:0] r, output logic z);
        int sa, sb, qi, ri;
        if (b == '0) begin
            q = '1; r = a; z = 1'b1;
        end else if (s) begin
            sa = $signed(a); sb = $signed(b);
            qi = sa / sb; ri = sa % sb;
            q = qi[W-1:0]; r = ri[W-1:0]; z = 1'b0;
        end else begin
            q = a / b; r = a % b; z = 1'b0;
        end
    endtask

    // Start an op, optionally pulse start again mid-run (R3), check results.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input bit poke);
        logic [W-1:0] eq, er;
        logic ez;
        int cyc;
        expect_of(a, b, s, eq, er, ez);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b; is_signed = s;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk("R2 busy after start", int'(busy), 1);
        while (!done && cyc < 40) begin
            if (poke && cyc == 2) begin
                start = 1'b1; dividend = ~a; divisor = 4'd1; is_signed = ~s;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(poke ? "R3 latency with ignored start" : "R2 latency", cyc, W + 3);
        chk("R2 busy low with done", int'(busy), 0);
        chk(s ? "R5 quotient" : "R4 quotient", int'(quotient), int'(eq));
        chk(s ? "R6 remainder" : "R4 remainder", int'(remainder), int'(er));
        chk("R7 div_by_zero", int'(div_by_zero), int'(ez));
        @(negedge clk);
        chk("R2 done one cycle", int'(done), 0);
        if (poke) begin
            for (int k = 0; k < W + 4; k++) begin
                @(negedge clk);
                chk("R3 no extra done", int'(done), 0);
            end
            chk("R3 result kept", int'(quotient), int'(eq));
        end
    endtask

    initial begin
        #1;
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 quotient", int'(quotient), 0);
        chk("R1 remainder", int'(remainder), 0);
        chk("R1 div_by_zero", int'(div_by_zero), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 worked example: -7 / -2 = 3 rem -1
        run_op(4'b1001, 4'b1110, 1'b1, 1'b0);
        chk("R6 example quotient", int'(quotient), 3);
        chk("R6 example remainder", int'(remainder), 15);

        // R8: outputs hold while idle and with inputs changing
        dividend = 4'd5; divisor = 4'd0;
        repeat (6) @(negedge clk);
        chk("R8 quotient held", int'(quotient), 3);
        chk("R8 remainder held", int'(remainder), 15);

        // R7 followed by non-zero divisor clears the flag
        run_op(4'd9, 4'd0, 1'b0, 1'b0);
        run_op(4'd9, 4'd2, 1'b0, 1'b0);
        chk("R7 flag cleared", int'(div_by_zero), 0);

        // R3: start while busy ignored
        run_op(4'd13, 4'd3, 1'b0, 1'b1);

        // R4, R5, R6, R7: exhaustive sweep
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    run_op(W'(a), W'(b), m[0], 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule